// File: doc/BRIEF.md
# SDRAM Page-Mode Access Sequencer

This block turns requests from one internal bus master into SDRAM command cycles on a 16-bit data port. It remembers the open row of every bank. Each access is classed as a page hit or a page miss, and the block issues precharge, activate and column commands on a fixed schedule. Because the schedule is fixed, every access type has a known cycle count. The block handles three access sizes: a single halfword, a 32-bit word split into two beats, and an 8-beat burst.

A refresh timer asks for a refresh at a fixed interval. The refresh runs only while no access is in progress. Two static configuration pins change the timing. The registered-read pin adds one pipeline stage to read data. The clock-invert pin drives the memory clock in antiphase to the internal clock, so its rising edge lands half a period after the command and data outputs change.

The master side uses a request/acknowledge handshake. Back-pressure works like this: the master raises `req` and holds the address, size, direction and write data steady. The block pulses `ack` once per beat, and ack cycles for the beats of one access are consecutive. After an ack the master may move the write data to the next beat. After the last ack it must drop or replace the request. The block cannot be stalled mid-access.

Top module: `sdram_page_seq`

## Requirements
- R1: A page hit means the addressed bank holds a valid open row equal to the addressed row; anything else is a page miss. The cycle in which the idle block first sees `req` is cycle 1. With registered-read off, the first `ack` of a read comes in cycle 7 on a miss and in cycle 5 on a hit.
- R2: With `cfg_regrd` high, every read acks one cycle later (8 on a miss, 6 on a hit). Write timing does not change.
- R3: The first `ack` of a write comes in cycle 5 on a miss and in cycle 3 on a hit.
- R4: A 32-bit access (`req_size`=1) gives two acks in consecutive cycles. The second beat uses the next column.
- R5: A burst (`req_size`=2) gives eight acks in consecutive cycles. Burst reads total 14/12 cycles (15/13 with registered-read); burst writes total 12/10 cycles (miss/hit).
- R6: Commands use `{ras_n,cas_n,we_n}` with chip select low: NOP 111, PRE 010, ACT 011, RD 101, WR 100, REF 001. A miss issues PRE in cycle 2, then ACT with the row on `sd_addr` in cycle 3, before any column command. A hit issues no PRE or ACT.
- R7: In a read ack cycle, `rdata` equals the value `sd_dq_in` held one cycle earlier with registered-read off, or two cycles earlier with it on.
- R8: In a write ack cycle the command is WR, `sd_dq_oe` is high, `sd_dq_out` equals `wdata`, and the column on `sd_addr` is the beat's column.
- R9: With no traffic, REF commands are exactly `REF_PERIOD` cycles apart. Each REF follows a precharge-all (PRE with `sd_addr[10]` high) in the cycle before it. No ack is given during a refresh.
- R10: A refresh closes every row, so the next access is a page miss.
- R11: With `cfg_clkinv` low, `sd_clk` follows `clk`. With it high, `sd_clk` is the inverse of `clk`.
- R12: During reset, `ack` is low, the command is NOP and `sd_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_regrd | input | 1 | Registered-read option |
| cfg_clkinv | input | 1 | Memory clock invert option |
| req | input | 1 | Access request, held until the last ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 halfword, 1 two-beat word, 2 eight-beat burst |
| req_addr | input | ROWW+BAW+COLW | Halfword address {row, bank, column} |
| wdata | input | 16 | Write data of the current beat |
| ack | output | 1 | Beat complete; read data valid |
| rdata | output | 16 | Read data |
| sd_clk | output | 1 | Memory clock |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BAW | Bank address |
| sd_addr | output | ROWW | Row/column address, bit 10 selects all banks on precharge |
| sd_dq_out | output | 16 | Write data to memory |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 16 | Read data from memory |

## Verification
The assertions check, on every cycle, the following local rules: an activate always follows a precharge, a write ack always coincides with a WR command, a pending refresh is never lost, a refresh clears every open row, and no ack overlaps a refresh. Only the bench scenarios can show the cycle counts of each access type in the hit, miss and registered-read cases, and the exact refresh interval. The same holds for the data alignment between `sd_dq_in` and `rdata` and for the phase of the memory clock.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  typedef enum logic [2:0] {C_NOP, C_PRE, C_ACT, C_RD, C_WR, C_REF} sd_cmd_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_REF} seq_st_t;

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_pins(sd_cmd_t c);
    case (c)
      C_PRE:   cmd_pins = 3'b010;
      C_ACT:   cmd_pins = 3'b011;
      C_RD:    cmd_pins = 3'b101;
      C_WR:    cmd_pins = 3'b100;
      C_REF:   cmd_pins = 3'b001;
      default: cmd_pins = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/sdseq_refresh_timer.sv
module sdseq_refresh_timer #(
  parameter int PERIOD = 61
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic pend
);
  localparam int CW = $clog2(PERIOD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CW'(PERIOD - 1);
      pend <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= CW'(PERIOD - 1);
      pend <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
      if (take) pend <= 1'b0;
    end
  end

  assert_pend_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (pend && !take) |=> pend);
endmodule

// File: rtl/sdseq_row_track.sv
module sdseq_row_track #(
  parameter int BAW  = 2,
  parameter int ROWW = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BAW-1:0]  q_bank,
  input  logic [ROWW-1:0] q_row,
  output logic            hit,
  input  logic            act_en,
  input  logic [BAW-1:0]  act_bank,
  input  logic [ROWW-1:0] act_row,
  input  logic            clear_all
);
  localparam int BANKS = 1 << BAW;
  logic [BANKS-1:0] valid;
  logic [ROWW-1:0]  row_q [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst || clear_all) begin
        valid[b] <= 1'b0;
        row_q[b] <= '0;
      end else if (act_en && act_bank == BAW'(b)) begin
        valid[b] <= 1'b1;
        row_q[b] <= act_row;
      end
    end
  end

  assign hit = valid[q_bank] && (row_q[q_bank] == q_row);

  assert_closed_after_refresh_R10: assert property (@(posedge clk) disable iff (rst)
    clear_all |=> !hit);
endmodule

// File: rtl/sdseq_cmd_seq.sv
module sdseq_cmd_seq
  import sdseq_pkg::*;
#(
  parameter int BAW  = 2,
  parameter int ROWW = 12,
  parameter int COLW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_regrd,
  input  logic            req,
  input  logic            req_we,
  input  logic [1:0]      req_size,
  input  logic [COLW-1:0] in_col,
  input  logic [BAW-1:0]  in_bank,
  input  logic [ROWW-1:0] in_row,
  input  logic            hit_in,
  input  logic            ref_pend,
  output logic            ref_take,
  output logic            act_en,
  output logic [BAW-1:0]  l_bank,
  output logic [ROWW-1:0] l_row,
  output logic            clear_all,
  output sd_cmd_t         cmd,
  output logic [ROWW-1:0] cmd_addr,
  output logic            ack,
  output logic            dq_oe
);
  localparam int CNTW = 5;
  seq_st_t         st;
  logic [CNTW-1:0] cnt, col_at, ack_at, col_end, last, off;
  logic            l_miss, l_we;
  logic [3:0]      l_beats;
  logic [COLW-1:0] l_col, cur_col;
  logic            in_col_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      l_miss  <= 1'b0;
      l_we    <= 1'b0;
      l_beats <= 4'd1;
      l_col   <= '0;
      l_bank  <= '0;
      l_row   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ref_pend) begin
            st  <= ST_REF;
            cnt <= CNTW'(1);
          end else if (req) begin
            st      <= ST_ACC;
            cnt     <= CNTW'(1);
            l_miss  <= !hit_in;
            l_we    <= req_we;
            l_beats <= (req_size == 2'd2) ? 4'd8 : (req_size == 2'd1) ? 4'd2 : 4'd1;
            l_col   <= in_col;
            l_bank  <= in_bank;
            l_row   <= in_row;
          end
        end
        ST_ACC: begin
          if (cnt == last) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          if (cnt == CNTW'(2)) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      endcase
    end
  end

  // fixed schedule: column commands and acks are placed relative to cnt
  assign col_at     = l_miss ? CNTW'(4) : CNTW'(2);
  assign ack_at     = l_we ? col_at : ((l_miss ? CNTW'(6) : CNTW'(4)) + CNTW'(cfg_regrd));
  assign col_end    = col_at + CNTW'(l_beats) - CNTW'(1);
  assign last       = ack_at + CNTW'(l_beats) - CNTW'(1);
  assign off        = cnt - col_at;
  assign cur_col    = l_col + COLW'(off);
  assign in_col_win = (st == ST_ACC) && (cnt >= col_at) && (cnt <= col_end);

  assign ref_take  = (st == ST_IDLE) && ref_pend;
  assign clear_all = (st == ST_REF) && (cnt == CNTW'(2));
  assign ack       = (st == ST_ACC) && (cnt >= ack_at) && (cnt <= last);
  assign act_en    = (cmd == C_ACT);
  assign dq_oe     = (cmd == C_WR);

  always_comb begin
    cmd      = C_NOP;
    cmd_addr = '0;
    if (st == ST_REF) begin
      if (cnt == CNTW'(1)) begin
        cmd          = C_PRE;
        cmd_addr[10] = 1'b1;
      end else cmd = C_REF;
    end else if (st == ST_ACC) begin
      if (l_miss && cnt == CNTW'(1)) cmd = C_PRE;
      else if (l_miss && cnt == CNTW'(2)) begin
        cmd      = C_ACT;
        cmd_addr = l_row;
      end else if (in_col_win) begin
        cmd      = l_we ? C_WR : C_RD;
        cmd_addr = ROWW'(cur_col);
      end
    end
  end

  assert_act_after_pre_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT) |-> ($past(cmd) == C_PRE));
  assert_write_ack_on_wr_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && l_we) |-> (cmd == C_WR && dq_oe));
endmodule

// File: rtl/sdram_page_seq.sv
module sdram_page_seq
  import sdseq_pkg::*;
#(
  parameter int BAW        = 2,
  parameter int ROWW       = 12,
  parameter int COLW       = 8,
  parameter int DW         = 16,
  parameter int REF_PERIOD = 61,
  localparam int AW        = ROWW + BAW + COLW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_regrd,
  input  logic            cfg_clkinv,
  input  logic            req,
  input  logic            req_we,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   wdata,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  output logic            sd_clk,
  output logic            sd_cs_n,
  output logic            sd_ras_n,
  output logic            sd_cas_n,
  output logic            sd_we_n,
  output logic [BAW-1:0]  sd_ba,
  output logic [ROWW-1:0] sd_addr,
  output logic [DW-1:0]   sd_dq_out,
  output logic            sd_dq_oe,
  input  logic [DW-1:0]   sd_dq_in
);
  logic [COLW-1:0] a_col;
  logic [BAW-1:0]  a_bank, l_bank;
  logic [ROWW-1:0] a_row, l_row;
  logic            hit, pend, take, act_en, clear_all;
  sd_cmd_t         cmd;
  logic [DW-1:0]   rd_s1, rd_s2;

  assign {a_row, a_bank, a_col} = req_addr;

  sdseq_refresh_timer #(.PERIOD(REF_PERIOD)) u_ref (
    .clk(clk), .rst(rst), .take(take), .pend(pend));

  sdseq_row_track #(.BAW(BAW), .ROWW(ROWW)) u_rows (
    .clk(clk), .rst(rst), .q_bank(a_bank), .q_row(a_row), .hit(hit),
    .act_en(act_en), .act_bank(l_bank), .act_row(l_row), .clear_all(clear_all));

  sdseq_cmd_seq #(.BAW(BAW), .ROWW(ROWW), .COLW(COLW)) u_seq (
    .clk(clk), .rst(rst), .cfg_regrd(cfg_regrd), .req(req), .req_we(req_we),
    .req_size(req_size), .in_col(a_col), .in_bank(a_bank), .in_row(a_row),
    .hit_in(hit), .ref_pend(pend), .ref_take(take), .act_en(act_en),
    .l_bank(l_bank), .l_row(l_row), .clear_all(clear_all), .cmd(cmd),
    .cmd_addr(sd_addr), .ack(ack), .dq_oe(sd_dq_oe));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_s1 <= '0;
      rd_s2 <= '0;
    end else begin
      rd_s1 <= sd_dq_in;
      rd_s2 <= rd_s1;
    end
  end

  assign rdata     = cfg_regrd ? rd_s2 : rd_s1;
  assign sd_clk    = cfg_clkinv ? ~clk : clk;
  assign sd_cs_n   = 1'b0;
  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_pins(cmd);
  assign sd_ba     = l_bank;
  assign sd_dq_out = wdata;

  assert_no_ack_in_refresh_R9: assert property (@(posedge clk) disable iff (rst)
    ({sd_ras_n, sd_cas_n, sd_we_n} == 3'b001) |-> !ack);
endmodule

// File: tb/sdram_page_seq_bench.sv
`timescale 1ns/100ps
module sdram_page_seq_bench;
  localparam int BAW = 2, ROWW = 12, COLW = 8, DW = 16, PER = 300;
  localparam int AW = ROWW + BAW + COLW;
  localparam logic [2:0] P_NOP = 3'b111, P_PRE = 3'b010, P_ACT = 3'b011,
                         P_RD = 3'b101, P_WR = 3'b100, P_REF = 3'b001;

  logic clk = 1'b0, rst = 1'b1, cfg_regrd = 1'b0, cfg_clkinv = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [1:0] req_size = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] wdata = '0, rdata, sd_dq_out, tick = '0;
  logic ack, sd_clk, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BAW-1:0] sd_ba;
  logic [ROWW-1:0] sd_addr;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tick <= tick + 1'b1;

  sdram_page_seq #(.BAW(BAW), .ROWW(ROWW), .COLW(COLW), .DW(DW), .REF_PERIOD(PER)) u_sdram_page_seq (
    .clk(clk), .rst(rst), .cfg_regrd(cfg_regrd), .cfg_clkinv(cfg_clkinv),
    .req(req), .req_we(req_we), .req_size(req_size), .req_addr(req_addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .sd_clk(sd_clk), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(tick));

  function automatic logic [2:0] pins();
    return (sd_cs_n == 1'b0) ? {sd_ras_n, sd_cas_n, sd_we_n} : P_NOP;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_ref();
    int n = 0;
    while (n < 2 * PER) begin
      @(negedge clk);
      n++;
      if (pins() == P_REF) break;
    end
    chk(n < 2 * PER, "R9 refresh seen", n, PER);
  endtask

  // one access; checks latency, beat spacing, commands and data
  task automatic do_access(input bit we, input logic [1:0] sz, input int bank, input int row,
                           input int col, input bit miss, input int lat, input string tag);
    int beats = (sz == 2) ? 8 : (sz == 1) ? 2 : 1;
    int n = 0, got = 0, first = 0;
    bit saw_act = 0;
    @(posedge clk); #1;
    req = 1; req_we = we; req_size = sz;
    req_addr = {ROWW'(row), BAW'(bank), COLW'(col)};
    wdata = 16'hA000;
    while (got < beats && n < 40) begin
      @(negedge clk);
      n++;
      if (pins() == P_ACT || pins() == P_PRE) saw_act = 1;
      if (miss && n == 2) chk(pins() == P_PRE, {tag, " R6 PRE"}, int'(pins()), int'(P_PRE));
      if (miss && n == 3) chk(pins() == P_ACT && sd_addr == ROWW'(row) && sd_ba == BAW'(bank),
                              {tag, " R6 ACT row"}, int'(sd_addr), row);
      if (ack) begin
        if (got == 0) first = n;
        else chk(n == first + got, {tag, " R4/R5 consecutive ack"}, n, first + got);
        if (we) begin
          chk(pins() == P_WR && sd_dq_oe && sd_dq_out == wdata, {tag, " R8 write beat"},
              int'(sd_dq_out), int'(wdata));
          chk(sd_addr[COLW-1:0] == COLW'(col + got), {tag, " R4 column"},
              int'(sd_addr[COLW-1:0]), col + got);
        end else begin
          chk(rdata == (cfg_regrd ? tick - 16'd2 : tick - 16'd1), {tag, " R7 read data"},
              int'(rdata), int'(cfg_regrd ? tick - 16'd2 : tick - 16'd1));
        end
        got++;
        @(posedge clk); #1;
        if (got == beats) req = 0;
        else wdata = 16'hA000 + 16'(got);
      end
    end
    chk(first == lat, {tag, " latency"}, first, lat);
    chk(got == beats, {tag, " beat count"}, got, beats);
    if (!miss) chk(!saw_act, {tag, " R6 hit has no PRE/ACT"}, int'(saw_act), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!ack && pins() == P_NOP && !sd_dq_oe, "R12 reset state", int'(pins()), int'(P_NOP));
  endtask

  task automatic t_reads();
    wait_ref();
    do_access(0, 0, 1, 5, 3, 1, 7, "R1 read miss");
    do_access(0, 0, 1, 5, 9, 0, 5, "R1 read hit");
    do_access(0, 0, 1, 6, 9, 1, 7, "R1 same bank other row miss");
    do_access(0, 0, 2, 6, 9, 1, 7, "R1 other bank miss");
  endtask

  task automatic t_regread();
    cfg_regrd = 1;
    wait_ref();
    do_access(0, 0, 0, 9, 1, 1, 8, "R2 reg read miss");
    do_access(0, 0, 0, 9, 2, 0, 6, "R2 reg read hit");
    do_access(1, 0, 0, 9, 2, 0, 3, "R2 reg write hit unchanged");
    cfg_regrd = 0;
  endtask

  task automatic t_writes();
    wait_ref();
    do_access(1, 0, 3, 100, 4, 1, 5, "R3 write miss");
    do_access(1, 0, 3, 100, 5, 0, 3, "R3 write hit");
  endtask

  task automatic t_long();
    wait_ref();
    do_access(0, 1, 1, 7, 10, 1, 7, "R4 long read miss");
    do_access(1, 1, 1, 7, 20, 0, 3, "R4 long write hit");
  endtask

  task automatic t_burst();
    wait_ref();
    do_access(0, 2, 2, 33, 16, 1, 7, "R5 burst read miss");
    do_access(0, 2, 2, 33, 24, 0, 5, "R5 burst read hit");
    do_access(1, 2, 2, 40, 32, 1, 5, "R5 burst write miss");
    do_access(1, 2, 2, 40, 40, 0, 3, "R5 burst write hit");
    cfg_regrd = 1;
    do_access(0, 2, 2, 40, 48, 0, 6, "R5 burst reg read hit");
    cfg_regrd = 0;
  endtask

  task automatic t_refresh();
    int n = 0;
    bit pre_all = 0;
    wait_ref();
    while (n < 2 * PER) begin
      @(negedge clk);
      n++;
      if (pins() == P_PRE) pre_all = sd_addr[10];
      if (pins() == P_REF) break;
    end
    chk(n == PER, "R9 refresh interval", n, PER);
    chk(pre_all, "R9 precharge-all before REF", int'(pre_all), 1);
    do_access(0, 0, 1, 8, 0, 1, 7, "R10 open row");
    do_access(0, 0, 1, 8, 1, 0, 5, "R10 hit before refresh");
    wait_ref();
    do_access(0, 0, 1, 8, 2, 1, 7, "R10 miss after refresh");
  endtask

  task automatic t_clkinv();
    @(negedge clk);
    chk(sd_clk == 1'b0, "R11 clock in phase low", int'(sd_clk), 0);
    @(posedge clk); #1;
    chk(sd_clk == 1'b1, "R11 clock in phase high", int'(sd_clk), 1);
    cfg_clkinv = 1;
    @(negedge clk); #0.1;
    chk(sd_clk == 1'b1, "R11 inverted at clk low", int'(sd_clk), 1);
    @(posedge clk); #1;
    chk(sd_clk == 1'b0, "R11 inverted at clk high", int'(sd_clk), 0);
    cfg_clkinv = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1 rst = 0;
    t_reads();
    t_regread();
    t_writes();
    t_long();
    t_burst();
    t_refresh();
    t_clkinv();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule